// File: doc/BRIEF.md
# BCD Decade Rate Multiplier

This block thins a stream of enabled clock cycles into a lower pulse rate set by a single BCD digit. For every ten cycles on which `clk_en` is high and the unit is not held, `pulse_out` carries as many one-cycle pulses as the digit on `rate` asks for, from none up to nine. A decade counter steps through ten states. Each bit of the digit owns a fixed set of those states. Bit 3 owns eight states, bit 2 owns four, bit 1 owns two and bit 0 owns one. The pulses that a code produces are therefore spread across the decade rather than bunched at its start. Count state nine belongs to no weight, so that state never pulses.

Several digits chain into a multi-digit fraction. In a summing chain all units share the clock enable. A less significant unit has `hold_in` driven from the inverse of the more significant unit's `carry_out`, and its `pulse_out` feeds the upper unit's `cascade_in`. A 9 over a 4 then gives 94 pulses per 100 cycles. In a product chain the first unit's `pulse_out` is the second unit's `clk_en`, so a 9 followed by a 4 gives 36 pulses per 100 cycles. A synchronous clear and a synchronous preset-to-nine place the counter at a known phase. All control is sampled on `clk`.

Top module: `bcd_rate_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter goes to state 0. After that edge `pulse_out`, `carry_out` and `nine_flag` are 0 and `pulse_out_n` is 1.
- R2: Start from state 0 with `rate` held at a code N from 0 to 9. Over any ten advancing cycles, `pulse_out` shows exactly N pulses, and over one hundred it shows 10·N. The counter wraps from state 9 back to state 0.
- R3: Codes 10 to 15 saturate. Even codes give 8 pulses per decade and odd codes give 9. This is the same result as codes 8 and 9.
- R4: A cycle advances when `clk_en` is 1, `hold_in` is 0, `clear` is 0 and `preset_nine` is 0. The cycle after an advance from state s, `pulse_out` is high when `strobe` was 0 and s lies in a state set selected by `rate`. Bit 3 selects {0,1,2,3,5,6,7,8}, bit 2 selects {0,2,5,7}, bit 1 selects {1,6} and bit 0 selects {4}. In every other cycle the internal pulse is 0, so each pulse lasts one cycle.
- R5: `pulse_out_n` is always the inverse of `pulse_out`.
- R6: `clear` puts the counter in state 0 at the next edge, `preset_nine` puts it in state 9, and `clear` wins when both are high. Neither produces a pulse.
- R7: `nine_flag` is 1 exactly while the counter is in state 9.
- R8: `carry_out` is 1 exactly while the counter is in state 9 and `hold_in` is 0.
- R9: While `strobe` is 1, no pulses are produced, but the counter keeps advancing.
- R10: While `hold_in` is 1, the counter does not move and no pulses are produced.
- R11: `cascade_in` is ORed into `pulse_out` in the same cycle, with no register in the path.
- R12: In a summing chain, an upper digit of 9 over a lower digit of 4 gives 94 pulses in 100 cycles on the upper `pulse_out`.
- R13: In a product chain, a first digit of 9 followed by a second digit of 4 gives 36 pulses on the second unit's output for 100 input cycles.
- R14: A cycle with `clk_en` low leaves the counter unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Input pulse: one counted cycle when high |
| rate | input | 4 | BCD rate digit |
| strobe | input | 1 | Blocks output pulses while high; counting continues |
| cascade_in | input | 1 | Pulse stream merged onto the output |
| hold_in | input | 1 | Freezes the counter and silences output when high |
| preset_nine | input | 1 | Synchronous load of state 9 |
| clear | input | 1 | Synchronous load of state 0; beats preset_nine |
| pulse_out | output | 1 | Rate output (registered pulse OR cascade_in) |
| pulse_out_n | output | 1 | Inverse of pulse_out |
| carry_out | output | 1 | High in state 9 when not held; drives the next digit |
| nine_flag | output | 1 | High while the counter holds 9 |

## Verification
The counter and the internal pulse each sit behind one register. A pulse, a wrap, a clear or a preset caused by the inputs at an edge therefore shows up one cycle later. `pulse_out_n`, `carry_out` and the `cascade_in` merge are combinational on that register state and the current inputs, so they are due in the same cycle. The bench holds a behavioural model in integers. It drives inputs between edges, steps the model at each rising edge, and compares every output a short delay after that edge. At that point both the registered and the combinational results have settled. Pulse totals over 10, 20 and 100 cycles are counted from the same samples, with extra idle cycles at the end of the product chain so its one-cycle lag flushes out.

// File: rtl/bcd_rate_pkg.sv
// Package: shared constants, types and helpers for the BCD rate multiplier.
// Assumes a decimal decade (ten states) and a 4-bit BCD weight digit.
package bcd_rate_pkg;

    localparam int DECADE  = 10;
    localparam int RATE_W  = 4;
    localparam int CNT_W   = $clog2(DECADE);

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [DECADE-1:0] phase_mask_t;
    typedef logic [RATE_W-1:0] rate_t;

    // State sets owned by each weight bit, index 0 = weight 1.
    // Within any legal code the selected sets are disjoint; state 9 is never owned.
    localparam phase_mask_t PHASE_MASK [0:RATE_W-1] = '{
        10'b00_0001_0000,   // weight 1: state 4
        10'b00_0100_0010,   // weight 2: states 1,6
        10'b00_1010_0101,   // weight 4: states 0,2,5,7
        10'b01_1110_1111    // weight 8: states 0-3,5-8
    };

    // Fold codes above nine onto eight (even) or nine (odd).
    function automatic rate_t fold_rate(input rate_t code);
        rate_t folded;
        if (code > rate_t'(DECADE - 1))
            folded = {1'b1, {(RATE_W-2){1'b0}}, code[0]};
        else
            folded = code;
        return folded;
    endfunction

endpackage

// File: rtl/bcd_decade_counter.sv
// Module: bcd_decade_counter
// Modulo-DECADE state counter with synchronous clear and preset to the
// last state. Clear outranks preset; both outrank advancing.
// Assumes advance is already qualified by enable and hold.
module bcd_decade_counter
    import bcd_rate_pkg::*;
#(
    parameter int STATES = DECADE,
    parameter int W      = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         load_zero,
    input  logic         load_last,
    output logic [W-1:0] count,
    output logic         at_last
);

    localparam logic [W-1:0] LAST = W'(STATES - 1);

    logic [W-1:0] count_q;

    // State register: reset, loads, then wrap-around stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load_zero)
            count_q <= '0;
        else if (load_last)
            count_q <= LAST;
        else if (advance)
            count_q <= (count_q == LAST) ? '0 : count_q + W'(1);
    end

    // Terminal-state decode.
    always_comb begin
        at_last = (count_q == LAST);
    end

    assign count = count_q;

endmodule

// File: rtl/bcd_phase_decoder.sv
// Module: bcd_phase_decoder
// Folds the rate digit and tests whether the current counter state lies in
// the state set of any weight bit that the digit selects.
// Assumes count stays below DECADE.
module bcd_phase_decoder
    import bcd_rate_pkg::*;
#(
    parameter int RW = RATE_W,
    parameter int W  = CNT_W
) (
    input  logic [W-1:0]  count,
    input  logic [RW-1:0] rate,
    output logic          hit
);

    rate_t         code_eff;
    logic [RW-1:0] sel;

    // Saturate illegal BCD codes.
    always_comb begin
        code_eff = fold_rate(rate);
    end

    // One gate per weight bit against its owned states.
    for (genvar w = 0; w < RW; w++) begin : g_weight
        phase_mask_t mask_w;
        assign mask_w = PHASE_MASK[w];
        assign sel[w] = code_eff[w] & mask_w[count];
    end

    // Any selected weight owning this state fires.
    always_comb begin
        hit = |sel;
    end

endmodule

// File: rtl/bcd_pulse_stage.sv
// Module: bcd_pulse_stage
// Registers the fire decision into a one-cycle pulse and its complement,
// then merges an external cascade stream onto both.
// Assumes fire is already gated by advance and strobe.
module bcd_pulse_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic cascade_in,
    output logic pulse_out,
    output logic pulse_out_n
);

    logic pulse_q;
    logic pulse_n_q;

    // True and complement registers, kept as separate flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q   <= 1'b0;
            pulse_n_q <= 1'b1;
        end else begin
            pulse_q   <= fire;
            pulse_n_q <= ~fire;
        end
    end

    // Cascade merge in the same cycle.
    always_comb begin
        pulse_out   = pulse_q | cascade_in;
        pulse_out_n = pulse_n_q & ~cascade_in;
    end

endmodule

// File: rtl/bcd_rate_mult.sv
// Module: bcd_rate_mult (top)
// One BCD digit of a rate multiplier: N pulses per ten advancing cycles.
// Assumes all inputs are synchronous to clk; chaining is done outside.
module bcd_rate_mult
    import bcd_rate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_en,
    input  logic [3:0]  rate,
    input  logic        strobe,
    input  logic        cascade_in,
    input  logic        hold_in,
    input  logic        preset_nine,
    input  logic        clear,
    output logic        pulse_out,
    output logic        pulse_out_n,
    output logic        carry_out,
    output logic        nine_flag
);

    count_t count_q;
    logic   at_last;
    logic   advance;
    logic   hit;
    logic   fire;

    // Qualify a counted step: enabled, not held, no load pending.
    always_comb begin
        advance = clk_en & ~hold_in & ~clear & ~preset_nine;
        fire    = advance & ~strobe & hit;
    end

    bcd_decade_counter #(.STATES(DECADE), .W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .load_zero (clear),
        .load_last (preset_nine),
        .count     (count_q),
        .at_last   (at_last)
    );

    bcd_phase_decoder #(.RW(RATE_W), .W(CNT_W)) u_decoder (
        .count (count_q),
        .rate  (rate),
        .hit   (hit)
    );

    bcd_pulse_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .cascade_in  (cascade_in),
        .pulse_out   (pulse_out),
        .pulse_out_n (pulse_out_n)
    );

    // Chain and status flags from the terminal state.
    always_comb begin
        nine_flag = at_last;
        carry_out = at_last & ~hold_in;
    end

endmodule

// File: rtl/bcd_rate_mult_chk.sv
// Module: bcd_rate_mult_chk
// Temporal checks on the rate multiplier, bound into every instance.
module bcd_rate_mult_chk
    import bcd_rate_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   clk_en,
    input logic   strobe,
    input logic   cascade_in,
    input logic   hold_in,
    input logic   preset_nine,
    input logic   clear,
    input logic   pulse_out,
    input logic   pulse_out_n,
    input logic   nine_flag,
    input count_t count_q
);

    // R5
    comp_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out_n != pulse_out);

    // R6
    clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count_q == '0);

    // R6
    preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_nine && !clear) |=> nine_flag);

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_flag && clk_en && !hold_in && !clear && !preset_nine) |=> count_q == '0);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < count_t'(DECADE));

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_in && !clear && !preset_nine) |=> ($stable(count_q) && pulse_out == cascade_in));

    // R9
    strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> pulse_out == cascade_in);

    // R14
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !clear && !preset_nine) |=> ($stable(count_q) && pulse_out == cascade_in));

    // R4
    nine_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nine_flag |=> pulse_out == cascade_in);

endmodule

bind bcd_rate_mult bcd_rate_mult_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .strobe      (strobe),
    .cascade_in  (cascade_in),
    .hold_in     (hold_in),
    .preset_nine (preset_nine),
    .clear       (clear),
    .pulse_out   (pulse_out),
    .pulse_out_n (pulse_out_n),
    .nine_flag   (nine_flag),
    .count_q     (count_q)
);

// File: tb/bcd_rate_mult_test.sv
// Bench for bcd_rate_mult: behavioural per-cycle model plus chain tests.
module bcd_rate_mult_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b0;
    logic [3:0] rate = 4'd0;
    logic strobe = 1'b0;
    logic cascade_in = 1'b0;
    logic hold_in = 1'b0;
    logic preset_nine = 1'b0;
    logic clear = 1'b0;
    logic pulse_out, pulse_out_n, carry_out, nine_flag;

    // Chain stimulus
    logic ce_s = 1'b0, clr_s = 1'b0, ce_p = 1'b0, clr_p = 1'b0;
    logic hi_out, hi_out_n, hi_carry, hi_nine;
    logic lo_out, lo_out_n, lo_carry, lo_nine;
    logic p1_out, p1_out_n, p1_carry, p1_nine;
    logic p2_out, p2_out_n, p2_carry, p2_nine;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    bit m_pq = 0;
    int pcount = 0;
    int sum_cnt = 0;
    int prod_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rate_mult uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rate(rate), .strobe(strobe),
        .cascade_in(cascade_in), .hold_in(hold_in), .preset_nine(preset_nine),
        .clear(clear), .pulse_out(pulse_out), .pulse_out_n(pulse_out_n),
        .carry_out(carry_out), .nine_flag(nine_flag));

    // Summing chain: upper digit 9, lower digit 4
    bcd_rate_mult u_hi (
        .clk(clk), .rst_n(rst_n), .clk_en(ce_s), .rate(4'd9), .strobe(1'b0),
        .cascade_in(lo_out), .hold_in(1'b0), .preset_nine(1'b0), .clear(clr_s),
        .pulse_out(hi_out), .pulse_out_n(hi_out_n), .carry_out(hi_carry), .nine_flag(hi_nine));
    bcd_rate_mult u_lo (
        .clk(clk), .rst_n(rst_n), .clk_en(ce_s), .rate(4'd4), .strobe(1'b0),
        .cascade_in(1'b0), .hold_in(~hi_carry), .preset_nine(1'b0), .clear(clr_s),
        .pulse_out(lo_out), .pulse_out_n(lo_out_n), .carry_out(lo_carry), .nine_flag(lo_nine));

    // Product chain: first digit 9 clocks second digit 4
    bcd_rate_mult u_p1 (
        .clk(clk), .rst_n(rst_n), .clk_en(ce_p), .rate(4'd9), .strobe(1'b0),
        .cascade_in(1'b0), .hold_in(1'b0), .preset_nine(1'b0), .clear(clr_p),
        .pulse_out(p1_out), .pulse_out_n(p1_out_n), .carry_out(p1_carry), .nine_flag(p1_nine));
    bcd_rate_mult u_p2 (
        .clk(clk), .rst_n(rst_n), .clk_en(p1_out), .rate(4'd4), .strobe(1'b0),
        .cascade_in(1'b0), .hold_in(1'b0), .preset_nine(1'b0), .clear(clr_p),
        .pulse_out(p2_out), .pulse_out_n(p2_out_n), .carry_out(p2_carry), .nine_flag(p2_nine));

    // Does state s pulse for code r (saturation applied)?
    function automatic bit owns(int s, int r);
        int e;
        bit b;
        e = (r > 9) ? (8 + (r % 2)) : r;
        b = 0;
        if ((e & 8) != 0 && s != 4 && s != 9) b = 1;
        if ((e & 4) != 0 && (s == 0 || s == 2 || s == 5 || s == 7)) b = 1;
        if ((e & 2) != 0 && (s == 1 || s == 6)) b = 1;
        if ((e & 1) != 0 && s == 4) b = 1;
        return b;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: model step, edge, compare all outputs.
    task automatic tick();
        int nc;
        bit np;
        nc = m_cnt;
        np = 0;
        if (!rst_n) nc = 0;
        else if (clear) nc = 0;
        else if (preset_nine) nc = 9;
        else if (clk_en && !hold_in) begin
            np = !strobe && owns(m_cnt, int'(rate));
            nc = (m_cnt + 1) % 10;
        end
        @(posedge clk);
        #1;
        m_cnt = nc;
        m_pq = np;
        check(pulse_out == (m_pq | cascade_in), "R4 pulse_out", int'(pulse_out), int'(m_pq | cascade_in));
        check(pulse_out_n == !(m_pq | cascade_in), "R5 pulse_out_n", int'(pulse_out_n), int'(!(m_pq | cascade_in)));
        check(nine_flag == (m_cnt == 9), "R7 nine_flag", int'(nine_flag), int'(m_cnt == 9));
        check(carry_out == (m_cnt == 9 && !hold_in), "R8 carry_out", int'(carry_out), int'(m_cnt == 9 && !hold_in));
        if (pulse_out) pcount++;
        if (hi_out) sum_cnt++;
        if (p2_out) prod_cnt++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_clear();
        clk_en = 0; clear = 1; tick(); clear = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #1;
        run(2);
        check(pulse_out == 0 && pulse_out_n == 1 && carry_out == 0 && nine_flag == 0,
              "R1 reset outputs", int'({pulse_out, pulse_out_n, carry_out, nine_flag}), 4);
        rst_n = 1;
        tick();

        // R2 / R3: every code over one decade
        for (int code = 0; code < 16; code++) begin
            rate = 4'(code);
            do_clear();
            pcount = 0;
            clk_en = 1;
            run(10);
            clk_en = 0;
            if (code < 10)
                check(pcount == code, "R2 pulses per decade", pcount, code);
            else
                check(pcount == 8 + (code % 2), "R3 saturated code", pcount, 8 + (code % 2));
        end

        // R2: hundred cycles for every legal code
        for (int code = 0; code < 10; code++) begin
            rate = 4'(code);
            do_clear();
            pcount = 0;
            clk_en = 1;
            run(100);
            clk_en = 0;
            check(pcount == 10 * code, "R2 pulses per hundred", pcount, 10 * code);
        end

        // R14: sparse enable, 10 enabled out of 20
        rate = 4'd5;
        do_clear();
        pcount = 0;
        for (int i = 0; i < 20; i++) begin
            clk_en = (i % 2 == 0);
            tick();
        end
        clk_en = 0;
        check(pcount == 5, "R14 sparse enable", pcount, 5);

        // R9: strobe blocks output, counter still runs
        rate = 4'd9;
        do_clear();
        pcount = 0;
        strobe = 1; clk_en = 1;
        run(9);
        check(nine_flag == 1, "R9 counter runs under strobe", int'(nine_flag), 1);
        tick();
        strobe = 0; clk_en = 0;
        check(pcount == 0, "R9 no pulses under strobe", pcount, 0);

        // R10: hold freezes the counter
        do_clear();
        pcount = 0;
        hold_in = 1; clk_en = 1;
        run(12);
        hold_in = 0; clk_en = 0;
        check(pcount == 0, "R10 no pulses under hold", pcount, 0);
        clk_en = 1;
        run(9);
        clk_en = 0;
        check(nine_flag == 1, "R10 counter did not move under hold", int'(nine_flag), 1);

        // R6: clear beats preset, preset loads nine
        clear = 1; preset_nine = 1; tick();
        clear = 0; preset_nine = 0;
        check(nine_flag == 0, "R6 clear priority", int'(nine_flag), 0);
        preset_nine = 1; tick(); preset_nine = 0;
        check(nine_flag == 1 && carry_out == 1, "R6 preset to nine", int'(nine_flag), 1);
        hold_in = 1; tick();
        check(carry_out == 0, "R8 carry gated by hold", int'(carry_out), 0);
        hold_in = 0;

        // R11: cascade merges combinationally
        rate = 4'd0;
        do_clear();
        cascade_in = 1; #2;
        check(pulse_out == 1 && pulse_out_n == 0, "R11 cascade merge", int'(pulse_out), 1);
        strobe = 1; clk_en = 1;
        run(3);
        strobe = 0; clk_en = 0; cascade_in = 0;
        tick();

        // R12: summing chain
        clr_s = 1; tick(); clr_s = 0;
        sum_cnt = 0;
        ce_s = 1;
        run(100);
        ce_s = 0;
        tick();
        check(sum_cnt == 94, "R12 summing chain", sum_cnt, 94);

        // R13: product chain
        clr_p = 1; tick(); clr_p = 0;
        prod_cnt = 0;
        ce_p = 1;
        run(100);
        ce_p = 0;
        run(3);
        check(prod_cnt == 36, "R13 product chain", prod_cnt, 36);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule